// File: doc/BRIEF.md
# Pipeline Hazard Detection and Stall Unit

This unit sits beside the decode stage of a five-stage pipeline that resolves branches in decode. It looks at the instruction held in decode and at the two instructions ahead of it, in execute and in memory. It finds the dependences that the forwarding network cannot cover. When it finds one, it freezes the program counter and the fetch/decode register and turns the next execute-stage entry into a bubble. The bubble is an all-zero entry that writes no register and stores nothing.

The unit is purely combinational. The held decode instruction is judged again on every cycle, so a stall lasts exactly as long as its cause. A load consumed by an ordinary instruction costs one bubble. An ALU result consumed by a branch or register jump also costs one bubble, because there is no execute-to-decode forwarding path. A load consumed by a branch or register jump costs two bubbles. After those two bubbles the value arrives through the register file, which is written before it is read.

Top module: `hz_stall_unit`

## Requirements
- R1: Whenever the unit stalls, `pc_ifid_load_en` is 0 and `idex_clear` is 1 in the same cycle. When it does not stall, `pc_ifid_load_en` is 1 and `idex_clear` is 0.
- R2: With no hazard present, `pc_ifid_load_en` stays 1 every cycle. A chain of ALU instructions that each read the previous result runs without a stall.
- R3: A load in execute whose destination equals a source of an ordinary instruction in decode causes exactly one bubble.
- R4: A branch or register jump in decode that reads the destination of an ALU instruction in execute causes exactly one bubble. The same ALU instruction in memory causes none.
- R5: A branch or register jump in decode that reads a load's destination stalls while the load is in execute and again while it is in memory. Directly behind the load this gives two bubbles. With one instruction between them it gives one bubble.
- R6: A destination of register 0, or a destination whose write-enable is 0, never causes a stall.
- R7: An all-zero entry (a bubble) in execute or memory never causes a stall. A stalled decode instruction is released as soon as its cause has moved on.
- R8: `id_cls` encoding: 0 = ordinary (compares rs and rt), 1 = branch (compares rs and rt), 2 = register jump (compares rs only), 3 = treated as ordinary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_cls | input | 2 | Class of the decode instruction (R8 encoding) |
| id_rs | input | REG_AW | First source register of the decode instruction |
| id_rt | input | REG_AW | Second source register of the decode instruction |
| ex_dst | input | REG_AW | Destination register of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_AW | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| pc_ifid_load_en | output | 1 | Update enable for the PC and fetch/decode register |
| idex_clear | output | 1 | Zeroes the decode/execute register (bubble) |

## Verification
The bench builds the unit with `REG_AW = 3`, so the register space has only eight names. At that size every pairing of decode sources with execute and memory destinations can be swept exhaustively, for every class, load flag and write-enable, including all register-0 cases. On top of that sweep, a small pipeline model in the bench moves instructions through execute and memory under the unit's own stall output. This lets instruction sequences be checked by the number of bubbles they produce, including the two-bubble branch-after-load case and the release after each stall.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_JREG   = 2'd2,
    CLS_SPARE  = 2'd3
  } id_cls_e;

  localparam int STG_EX   = 0;
  localparam int STG_MEM  = 1;
  localparam int NUM_LATE = 2;

  // Decides in decode, so it cannot take an execute-stage result.
  function automatic logic decides_in_id(id_cls_e c);
    return (c == CLS_BRANCH) || (c == CLS_JREG);
  endfunction

  // A register jump only consumes its first source.
  function automatic logic consumes_rt(id_cls_e c);
    return c != CLS_JREG;
  endfunction
endpackage

// File: rtl/hz_dep_check.sv
`timescale 1ns/1ps
module hz_dep_check #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] dst,
  input  logic              we,
  input  logic [REG_AW-1:0] rs,
  input  logic [REG_AW-1:0] rt,
  input  logic              rt_used,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  function automatic logic same_live_reg(logic [REG_AW-1:0] a, logic [REG_AW-1:0] b);
    return (a == b) && (a != ZERO_REG);
  endfunction

  logic rs_hit;
  logic rt_hit;

  always_comb begin
    rs_hit = we && same_live_reg(dst, rs);
    rt_hit = we && rt_used && same_live_reg(dst, rt);
    hit    = rs_hit || rt_hit;
  end

  always_comb begin
    if (!we)
      p_no_hit_without_write_r6: assert (!hit);
    if (dst == ZERO_REG)
      p_zero_reg_never_hits_r6: assert (!hit);
    if (!rt_used && rs != dst)
      p_jump_ignores_rt_r8: assert (!hit);
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
`timescale 1ns/1ps
module hz_stall_ctrl
  import hz_pkg::*;
(
  input  id_cls_e cls,
  input  logic    ex_hit,
  input  logic    ex_load,
  input  logic    mem_hit,
  input  logic    mem_load,
  output logic    stall
);
  logic ctrl;
  logic ev_load_use;
  logic ev_ctrl_after_alu;
  logic ev_ctrl_after_load_mem;

  always_comb begin
    ctrl                   = decides_in_id(cls);
    ev_load_use            = ex_hit && ex_load;
    ev_ctrl_after_alu      = ctrl && ex_hit && !ex_load;
    ev_ctrl_after_load_mem = ctrl && mem_hit && mem_load;
    stall = ev_load_use || ev_ctrl_after_alu || ev_ctrl_after_load_mem;
  end

  always_comb begin
    if (!ctrl && !ex_hit)
      p_plain_needs_ex_match_r3: assert (!stall);
    if (!ex_hit && !mem_hit)
      p_no_match_no_stall_r2: assert (!stall);
    if (ctrl && ex_hit)
      p_ctrl_waits_on_ex_r4: assert (stall);
  end
endmodule

// File: rtl/hz_stall_unit.sv
`timescale 1ns/1ps
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [1:0]        id_cls,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_we,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_we,
  input  logic              mem_load,
  output logic              pc_ifid_load_en,
  output logic              idex_clear
);
  id_cls_e            cls;
  logic [REG_AW-1:0]  late_dst [NUM_LATE];
  logic               late_we  [NUM_LATE];
  logic [NUM_LATE-1:0] late_hit;
  logic               stall;

  assign cls = id_cls_e'(id_cls);
  assign late_dst[STG_EX]  = ex_dst;
  assign late_dst[STG_MEM] = mem_dst;
  assign late_we[STG_EX]   = ex_we;
  assign late_we[STG_MEM]  = mem_we;

  for (genvar g = 0; g < NUM_LATE; g++) begin : g_stage
    hz_dep_check #(.REG_AW(REG_AW)) u_dep (
      .dst     (late_dst[g]),
      .we      (late_we[g]),
      .rs      (id_rs),
      .rt      (id_rt),
      .rt_used (consumes_rt(cls)),
      .hit     (late_hit[g])
    );
  end

  hz_stall_ctrl u_ctrl (
    .cls      (cls),
    .ex_hit   (late_hit[STG_EX]),
    .ex_load  (ex_load),
    .mem_hit  (late_hit[STG_MEM]),
    .mem_load (mem_load),
    .stall    (stall)
  );

  assign pc_ifid_load_en = !stall;
  assign idex_clear      = stall;

  always_comb begin
    if (!ex_we && !mem_we)
      p_idle_pipe_runs_r7: assert (pc_ifid_load_en && !idex_clear);
    if (ex_we && ex_load && ex_dst != '0 && id_rs == ex_dst)
      p_load_use_holds_r3: assert (!pc_ifid_load_en);
    if (decides_in_id(cls) && ex_we && !ex_load && ex_dst != '0 && id_rs == ex_dst)
      p_branch_alu_holds_r4: assert (!pc_ifid_load_en);
    if (decides_in_id(cls) && mem_we && mem_load && mem_dst != '0 && id_rs == mem_dst)
      p_branch_load_mem_holds_r5: assert (!pc_ifid_load_en);
    if (!ex_we && !mem_load)
      p_mem_alu_forwarded_r4: assert (pc_ifid_load_en);
  end
endmodule

// File: tb/tb_hz_stall_unit.sv
`timescale 1ns/1ps
module tb_hz_stall_unit;
  localparam int AW = 3;

  typedef struct packed {
    logic [1:0]    cls;
    logic [AW-1:0] rs;
    logic [AW-1:0] rt;
    logic [AW-1:0] dst;
    logic          we;
    logic          ld;
  } ins_t;

  localparam ins_t BUB = '0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  ins_t st_id = BUB, st_ex = BUB, st_mem = BUB;
  ins_t prog [8];

  logic load_en, clear;

  hz_stall_unit #(.REG_AW(AW)) dut (
    .id_cls(st_id.cls), .id_rs(st_id.rs), .id_rt(st_id.rt),
    .ex_dst(st_ex.dst), .ex_we(st_ex.we), .ex_load(st_ex.ld),
    .mem_dst(st_mem.dst), .mem_we(st_mem.we), .mem_load(st_mem.ld),
    .pc_ifid_load_en(load_en), .idex_clear(clear)
  );

  function automatic ins_t alu(int d, int s, int t);
    return '{cls: 2'd0, rs: AW'(s), rt: AW'(t), dst: AW'(d), we: 1'b1, ld: 1'b0};
  endfunction
  function automatic ins_t lod(int d, int base);
    return '{cls: 2'd0, rs: AW'(base), rt: '0, dst: AW'(d), we: 1'b1, ld: 1'b1};
  endfunction
  function automatic ins_t ctl(int c, int s, int t);
    return '{cls: 2'(c), rs: AW'(s), rt: AW'(t), dst: '0, we: 1'b0, ld: 1'b0};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs prog[0..n-1] through the modelled pipeline and counts bubbles.
  task automatic run_prog(input string req, input int n, input int exp_stalls);
    int idx = 1;
    int stalls = 0;
    int pair_bad = 0;
    logic held;
    st_mem = BUB; st_ex = BUB; st_id = prog[0];
    for (int cyc = 0; cyc < 3 * n + 3; cyc++) begin
      @(negedge clk);
      held = !load_en;
      if (held) stalls++;
      if (clear != held) pair_bad++;
      @(posedge clk);
      st_mem = st_ex;
      if (held) st_ex = BUB;
      else begin
        st_ex = st_id;
        st_id = (idx < n) ? prog[idx] : BUB;
        if (idx < n) idx++;
      end
    end
    check(req, stalls, exp_stalls);
    check("R1 clear/enable pairing", pair_bad, 0);
    st_id = BUB; st_ex = BUB; st_mem = BUB;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("R2 idle enable", int'(load_en), 1);
    check("R1 idle clear", int'(clear), 0);
  endtask

  task automatic t_alu_chain;
    prog[0] = alu(5, 3, 4); prog[1] = alu(6, 5, 6); prog[2] = alu(7, 7, 5);
    run_prog("R2 alu chain stalls", 3, 0);
  endtask

  task automatic t_load_use;
    prog[0] = lod(2, 1); prog[1] = alu(3, 2, 0);
    run_prog("R3 load-use on rs stalls", 2, 1);
    prog[0] = lod(2, 1); prog[1] = alu(4, 1, 2);
    run_prog("R3 load-use on rt stalls", 2, 1);
  endtask

  task automatic t_branch_alu;
    prog[0] = alu(3, 2, 3); prog[1] = alu(2, 4, 6); prog[2] = ctl(1, 3, 5);
    prog[3] = alu(2, 2, 3); prog[4] = ctl(1, 3, 2);
    run_prog("R4 branch after alu stalls", 5, 1);
  endtask

  task automatic t_branch_load;
    prog[0] = lod(4, 6); prog[1] = ctl(1, 4, 0);
    run_prog("R5 branch after load stalls", 2, 2);
    prog[0] = lod(4, 6); prog[1] = ctl(2, 4, 0);
    run_prog("R5 jump after load stalls", 2, 2);
    prog[0] = lod(1, 6); prog[1] = alu(5, 6, 7); prog[2] = ctl(1, 2, 1);
    run_prog("R5 branch one behind load stalls", 3, 1);
  endtask

  task automatic t_ignored;
    prog[0] = alu(0, 1, 2); prog[1] = ctl(1, 0, 0);
    run_prog("R6 reg0 alu dest stalls", 2, 0);
    prog[0] = lod(0, 1); prog[1] = alu(3, 0, 0);
    run_prog("R6 reg0 load dest stalls", 2, 0);
    prog[0] = alu(3, 1, 2); prog[0].we = 1'b0; prog[1] = ctl(1, 3, 3);
    run_prog("R6 no-write dest stalls", 2, 0);
  endtask

  task automatic t_classes;
    prog[0] = alu(2, 1, 1); prog[1] = ctl(2, 1, 2);
    run_prog("R8 jump ignores rt stalls", 2, 0);
    prog[0] = lod(2, 1); prog[1] = ctl(3, 5, 2);
    run_prog("R8 spare class load-use stalls", 2, 1);
    prog[0] = alu(2, 1, 1); prog[1] = ctl(3, 2, 2);
    run_prog("R8 spare class after alu stalls", 2, 0);
  endtask

  task automatic t_bubble;
    st_id = ctl(1, 0, 0); st_ex = BUB; st_mem = BUB;
    @(negedge clk);
    check("R7 bubble in ex/mem enable", int'(load_en), 1);
    st_id = BUB;
  endtask

  // Every decode/producer pairing at the 3-bit register size.
  task automatic t_sweep;
    int bad = 0;
    for (int stg = 0; stg < 2; stg++)
      for (int c = 0; c < 4; c++)
        for (int d = 0; d < 8; d++)
          for (int s = 0; s < 8; s++)
            for (int w = 0; w < 2; w++)
              for (int l = 0; l < 2; l++) begin
                ins_t p;
                bit uses, live, branchy, exp;
                int t;
                t = (s * 5 + d + c) % 8;
                st_id = ctl(c, s, t);
                p = alu(d, 0, 0); p.we = w[0]; p.ld = l[0];
                if (stg == 0) begin st_ex = p; st_mem = BUB; end
                else begin st_mem = p; st_ex = BUB; end
                uses = (s == d) || (c != 2 && t == d);
                live = (w == 1) && (d != 0) && uses;
                branchy = (c == 1) || (c == 2);
                exp = (stg == 0) ? (live && (l == 1 || branchy))
                                 : (live && l == 1 && branchy);
                #1;
                compared++;
                if (load_en !== !exp || clear !== exp) begin
                  mismatched++; bad++;
                  if (bad < 6)
                    $display("FAIL R3/R4/R5/R6 sweep stg%0d cls%0d dst%0d rs%0d rt%0d we%0d ld%0d: actual en=%0d expected en=%0d",
                             stg, c, d, s, t, w, l, load_en, !exp);
                end
              end
    st_id = BUB; st_ex = BUB; st_mem = BUB;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_alu_chain();
    t_load_use();
    t_branch_alu();
    t_branch_load();
    t_ignored();
    t_classes();
    t_bubble();
    t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule